// File: doc/BRIEF.md
# Sticky Right Shifter

This block shifts a significand to the right by a variable amount without losing track of what falls off the low end. Any set bit that drops below bit 0 is ORed into bit 0 of the result as a sticky bit. A later rounding stage can then tell an exact result from an inexact one. If the shift amount is at least the operand width, the whole operand is discarded and the result is a single sticky bit.

A second mode narrows a wide value to its upper half. The low half of the input is folded into bit 0 of the narrowed result. The block is purely combinational. One parameter sets the operand width to 32 or 64 bits, and an 8-bit amount input selects the shift distance.

Top module: `sticky_rshift`

## Requirements
- R1: In shift mode (mode_i = 0), a shift amount of zero gives a result equal to the operand.
- R2: In shift mode, for an amount from 1 to WIDTH-1, the result is the logical right shift of the operand, with bit 0 ORed with the OR of every bit shifted out.
- R3: In shift mode, for an amount of WIDTH or more (up to 255), the result is 1 when the operand is nonzero and 0 when it is zero.
- R4: In shift mode, the result is nonzero exactly when the operand is nonzero, and it is never numerically larger than the operand.
- R5: In narrow mode (mode_i = 1), result bits WIDTH/2-1:0 hold operand bits WIDTH-1:WIDTH/2, bit 0 is forced to 1 when operand bits WIDTH/2-1:0 are nonzero, and result bits WIDTH-1:WIDTH/2 are zero. With WIDTH = 64, this keeps bits 63:32.
- R6: In narrow mode, the shift amount has no effect on the result.
- R7: WIDTH may be 32 or 64, and the shift amount input is 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH | Value to shift or narrow |
| shamt_i | input | SHAMT_W (8) | Right shift distance, unsigned |
| mode_i | input | 1 | 0 = sticky shift, 1 = narrow to upper half |
| result_o | output | WIDTH | Shifted or narrowed value |

## Verification
The bench builds the block twice, once with WIDTH = 64 and once with WIDTH = 32, and keeps the default 8-bit amount in both. The 64-bit build covers the wide narrowing case and amounts up to 63 on the in-range path. The 32-bit build reaches the saturation boundary at 32, so amounts from 32 to 63 must collapse there while the same values would still shift normally at 64. For both builds, a loop-based reference model gives the expected value of every amount from 0 to 255. It is used on a sweep and on pseudo-random operands.

// File: rtl/sticky_shift_pkg.sv
package sticky_shift_pkg;

    typedef enum logic {
        SSH_SHIFT  = 1'b0,
        SSH_NARROW = 1'b1
    } ssh_mode_e;

endpackage

// File: rtl/ssh_barrel.sv
module ssh_barrel #(
    parameter int WIDTH   = 64,
    parameter int SHAMT_W = 8
) (
    input  logic [WIDTH-1:0]   data_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [WIDTH-1:0]   data_o,
    output logic               sticky_o
);
    localparam int STAGES = $clog2(WIDTH);

    logic [STAGES:0][WIDTH-1:0] val_s;
    logic [STAGES:0]            stk_s;

    assign val_s[0] = data_i;
    assign stk_s[0] = 1'b0;

    // one stage per amount bit below the saturation range
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign val_s[k+1] = amt_i[k] ? (val_s[k] >> SH) : val_s[k];
        assign stk_s[k+1] = stk_s[k] | (amt_i[k] & (|val_s[k][SH-1:0]));
    end

    assign data_o   = val_s[STAGES];
    assign sticky_o = stk_s[STAGES];

    // R2: vacated upper bits must be clear after an in-range shift
    logic [STAGES-1:0] amt_low;
    assign amt_low = amt_i[STAGES-1:0];
    always_comb begin
        // R2
        vacated_clear_chk: assert (amt_low == '0 ||
            (data_o >> (WIDTH - int'(amt_low))) == '0);
    end

endmodule

// File: rtl/ssh_narrow.sv
module ssh_narrow #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);
    localparam int HALF = WIDTH / 2;

    logic [HALF-1:0] hi_part;
    logic            lo_any;

    assign hi_part = data_i[WIDTH-1:HALF];
    assign lo_any  = |data_i[HALF-1:0];
    assign data_o  = {{HALF{1'b0}}, hi_part[HALF-1:1], hi_part[0] | lo_any};

endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift
    import sticky_shift_pkg::*;
#(
    parameter int WIDTH   = 64,
    parameter int SHAMT_W = 8
) (
    input  logic [WIDTH-1:0]   operand_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               mode_i,
    output logic [WIDTH-1:0]   result_o
);
    localparam int STAGES = $clog2(WIDTH);
    localparam int HALF   = WIDTH / 2;

    if (WIDTH != 32 && WIDTH != 64) begin : g_bad_width
        $error("sticky_rshift: WIDTH must be 32 or 64");
    end

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             saturated;
    } res_t;

    ssh_mode_e        mode;
    logic [WIDTH-1:0] shifted;
    logic             sticky;
    logic [WIDTH-1:0] narrowed;
    logic             over_range;
    res_t             res_d;

    assign mode       = ssh_mode_e'(mode_i);
    assign over_range = |shamt_i[SHAMT_W-1:STAGES];

    ssh_barrel #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) barrel_i (
        .data_i   (operand_i),
        .amt_i    (shamt_i),
        .data_o   (shifted),
        .sticky_o (sticky)
    );

    ssh_narrow #(.WIDTH(WIDTH)) narrow_i (
        .data_i (operand_i),
        .data_o (narrowed)
    );

    always_comb begin
        res_d = '0;
        if (mode == SSH_NARROW) begin
            res_d.value = narrowed;
        end else if (over_range) begin
            res_d.saturated = 1'b1;
            res_d.value     = {{(WIDTH-1){1'b0}}, |operand_i};
        end else begin
            res_d.value = {shifted[WIDTH-1:1], shifted[0] | sticky};
        end
    end

    assign result_o = res_d.value;

    always_comb begin
        if (mode == SSH_SHIFT) begin
            // R1
            zero_shift_chk: assert (shamt_i != '0 || result_o == operand_i);
            // R4
            nonzero_keep_chk: assert ((result_o != '0) == (operand_i != '0));
            // R4
            no_growth_chk: assert (result_o <= operand_i);
        end else begin
            // R5
            narrow_upper_chk: assert (result_o[WIDTH-1:HALF] == '0);
        end
    end

endmodule

// File: tb/sticky_rshift_tb.sv
module sticky_rshift_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [63:0] op64;
    logic [7:0]  sh64;
    logic        md64;
    logic [63:0] res64;
    logic [31:0] op32;
    logic [7:0]  sh32;
    logic        md32;
    logic [31:0] res32;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sticky_rshift #(.WIDTH(64), .SHAMT_W(8)) dut_i (
        .operand_i (op64), .shamt_i (sh64), .mode_i (md64), .result_o (res64));

    sticky_rshift #(.WIDTH(32), .SHAMT_W(8)) dut32_i (
        .operand_i (op32), .shamt_i (sh32), .mode_i (md32), .result_o (res32));

    typedef struct packed {
        logic [63:0] op;
        logic [7:0]  sh;
        logic        md;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_00F0, 8'd4,   1'b0, 64'h0000_0000_0000_000F},
        '{64'h0000_0000_0000_0100, 8'd4,   1'b0, 64'h0000_0000_0000_0010},
        '{64'h0000_0000_0000_0101, 8'd4,   1'b0, 64'h0000_0000_0000_0011},
        '{64'h0000_0000_0000_0030, 8'd4,   1'b0, 64'h0000_0000_0000_0003},
        '{64'h0000_0000_0000_0018, 8'd4,   1'b0, 64'h0000_0000_0000_0001},
        '{64'h0000_0000_0000_0001, 8'd1,   1'b0, 64'h0000_0000_0000_0001},
        '{64'h8000_0000_0000_0000, 8'd63,  1'b0, 64'h0000_0000_0000_0001},
        '{64'h8000_0000_0000_0001, 8'd63,  1'b0, 64'h0000_0000_0000_0001},
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'd60,  1'b0, 64'h0000_0000_0000_000F},
        '{64'h1234_5678_9ABC_DEF0, 8'd0,   1'b0, 64'h1234_5678_9ABC_DEF0},
        '{64'h0000_0000_0000_0005, 8'd64,  1'b0, 64'h0000_0000_0000_0001},
        '{64'h0000_0000_0000_0000, 8'd255, 1'b0, 64'h0000_0000_0000_0000},
        '{64'h8000_0000_0000_0000, 8'd200, 1'b0, 64'h0000_0000_0000_0001},
        '{64'h0000_0000_0000_0000, 8'd17,  1'b0, 64'h0000_0000_0000_0000},
        '{64'h1234_5678_0000_0000, 8'd0,   1'b1, 64'h0000_0000_1234_5678},
        '{64'h1234_5678_0000_0001, 8'd0,   1'b1, 64'h0000_0000_1234_5679},
        '{64'h1234_5670_0000_0010, 8'd7,   1'b1, 64'h0000_0000_1234_5671},
        '{64'h0000_0000_FFFF_FFFF, 8'd99,  1'b1, 64'h0000_0000_0000_0001},
        '{64'hFFFF_FFFF_8000_0000, 8'd255, 1'b1, 64'h0000_0000_FFFF_FFFF},
        '{64'h0000_0000_0000_0000, 8'd0,   1'b1, 64'h0000_0000_0000_0000}
    };

    function automatic logic [63:0] ref_model(logic [63:0] v, int sh, logic md, int w);
        logic [63:0] r = '0;
        logic        st = 1'b0;
        int          h = w / 2;
        if (md) begin
            for (int i = 0; i < h; i++) begin
                r[i] = v[i+h];
                st   = st | v[i];
            end
        end else begin
            for (int i = 0; i < w; i++) begin
                if (i < sh) st = st | v[i];
                else        r[i-sh] = v[i];
            end
        end
        r[0] = r[0] | st;
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run64(string tag, logic [63:0] v, logic [7:0] s, logic m, logic [63:0] exp);
        @(posedge clk);
        op64 <= v; sh64 <= s; md64 <= m;
        @(negedge clk);
        check(tag, res64, exp);
    endtask

    task automatic run32(string tag, logic [31:0] v, logic [7:0] s, logic m);
        @(posedge clk);
        op32 <= v; sh32 <= s; md32 <= m;
        @(negedge clk);
        check(tag, {32'h0, res32}, ref_model({32'h0, v}, int'(s), m, 32));
    endtask

    function automatic string tag_for(logic m, int s, int w);
        if (m)      return "R5";
        if (s == 0) return "R1";
        if (s < w)  return "R2";
        return "R3";
    endfunction

    initial begin
        logic [63:0] lfsr = 64'hACE1_2468_1357_BDF9;
        op64 = '0; sh64 = '0; md64 = 1'b0;
        op32 = '0; sh32 = '0; md32 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: all-zero inputs give a zero result
        @(negedge clk);
        check("R1 idle 64", res64, 64'h0);
        check("R1 idle 32", {32'h0, res32}, 64'h0);

        // table of hand-computed vectors
        for (int i = 0; i < NV; i++)
            run64(tag_for(VECS[i].md, int'(VECS[i].sh), 64),
                  VECS[i].op, VECS[i].sh, VECS[i].md, VECS[i].exp);

        // R2 R3 R7: sweep every amount on both widths
        for (int s = 0; s < 256; s++) begin
            run64(tag_for(1'b0, s, 64), 64'hF00D_0000_0000_0003, 8'(s), 1'b0,
                  ref_model(64'hF00D_0000_0000_0003, s, 1'b0, 64));
            run32(tag_for(1'b0, s, 32), 32'h8000_0101, 8'(s), 1'b0);
        end

        // R3 boundary on the 32-bit build: 31 shifts, 32 saturates
        run32("R3 w32 amt31", 32'hC000_0000, 8'd31, 1'b0);
        run32("R3 w32 amt32", 32'hC000_0000, 8'd32, 1'b0);
        run32("R3 w32 zero", 32'h0, 8'd40, 1'b0);

        // R6: amount ignored in narrow mode
        for (int s = 0; s < 256; s += 17) begin
            run64("R6 narrow amount", 64'hDEAD_BEEE_0000_0100, 8'(s), 1'b1, 64'h0000_0000_DEAD_BEEF);
            run32("R6 narrow amount w32", 32'hBEEE_0001, 8'(s), 1'b1);
        end

        // pseudo-random operands, amounts and modes
        for (int n = 0; n < 600; n++) begin
            logic [63:0] v;
            logic [7:0]  s;
            logic        m;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            v = lfsr;
            if (lfsr[5]) v = v & (64'hFFFF >> lfsr[3:0]);
            s = lfsr[2] ? {2'b00, lfsr[13:8]} : lfsr[23:16];
            m = (lfsr[31:29] == 3'b000);
            run64(tag_for(m, int'(s), 64), v, s, m, ref_model(v, int'(s), m, 64));
            run32(tag_for(m, int'(s), 32), v[31:0], s, m);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

endmodule